// File: doc/BRIEF.md
# Bistable Pulse Decoder with Watchdog

This block is the receiving end of one isolated logic channel. The far side sends two kinds of short pulse. A set pulse means the line is high and a clear pulse means the line is low. Each pulse lasts one clock. The sender emits a pulse on every input edge. It also repeats the current level at a regular refresh interval. The decoder keeps the last level it was told in a bistable register and drives that level out. It does not need a continuous signal.

A watchdog measures how many cycles have passed since the last pulse. Too long a silence means the sending side has lost power or stopped working. The decoder then drives the safe default level, which is low, and drops the link-valid flag. A local power-good input works the same way while the receiving side is below its undervoltage threshold. It holds the output low and the link invalid, and any pulses in that time are ignored.

All pins are plain control and status levels sampled on the rising clock edge. There is no valid/ready handshake and no back-pressure: a pulse present at an edge is taken at that edge and cannot be stalled. The `TIMEOUT_CYC` parameter is the watchdog limit in clocks. It must be at least 2 and well above the sender's refresh interval.

Top module: `iso_pulse_rx`

## Requirements
- R1: With `pwr_ok` high, a set pulse without a clear pulse at a rising edge makes `dout` 1 after that edge.
- R2: With `pwr_ok` high, a clear pulse at a rising edge makes `dout` 0 after that edge.
- R3: With `pwr_ok` high and no pulse at an edge, `dout` keeps its value unless the watchdog expires at that edge (R6).
- R4: A set pulse and a clear pulse at the same edge act as a clear: `dout` becomes 0. The edge still counts as activity, so `link_ok` is 1 after it.
- R5: Any pulse taken while `pwr_ok` is high makes `link_ok` 1 after that edge and restarts the watchdog count from zero.
- R6: After the edge that took a pulse, `TIMEOUT_CYC` pulse-free edges in a row make both `dout` and `link_ok` 0 after the last of them. After only `TIMEOUT_CYC`-1 such edges, both keep their values.
- R7: At an edge where `pwr_ok` is low, `dout` and `link_ok` become 0 and any pulses are ignored.
- R8: After `rst_n` is released, and after `pwr_ok` returns, `dout` and `link_ok` are 0 and stay 0 until a pulse is taken. The first set pulse then raises `dout`.
- R9: A sender that repeats set pulses with fewer than `TIMEOUT_CYC` pulse-free edges between them keeps `dout` at 1 and `link_ok` at 1 at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Receiving-side power is above its undervoltage threshold |
| set_pulse | input | 1 | One-cycle pulse meaning the remote level is high |
| clr_pulse | input | 1 | One-cycle pulse meaning the remote level is low |
| dout | output | 1 | Decoded level held between pulses, 0 by default |
| link_ok | output | 1 | The link is considered alive |

## Verification
The checker tests these rules on every cycle:
- the edge-by-edge responses to set, clear, simultaneous pulses and power loss;
- that `dout` can only rise just after a set pulse;
- that a silence of `TIMEOUT_CYC` edges always leaves both outputs low. A separate idle counter tracks that silence.

Some behaviours need bench scenarios to show them:
- The exact cycle where the watchdog trips, one edge before and at the limit.
- Recovery after a timeout.
- A long run of periodic refreshes that never trips the watchdog.
- The startup sequence after reset and after power returns, where the output waits for its first pulse.

// File: rtl/iso_pulse_rx_pkg.sv
package iso_pulse_rx_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SET  = 2'd1,
    EV_CLR  = 2'd2
  } pulse_ev_t;
endpackage

// File: rtl/iso_pulse_ev.sv
module iso_pulse_ev
  import iso_pulse_rx_pkg::*;
(
  input  logic      pwr_ok,
  input  logic      set_pulse,
  input  logic      clr_pulse,
  output pulse_ev_t ev,
  output logic      act
);
  // clear has priority over set; nothing is accepted while unpowered
  always_comb begin
    if (!pwr_ok)        ev = EV_NONE;
    else if (clr_pulse) ev = EV_CLR;
    else if (set_pulse) ev = EV_SET;
    else                ev = EV_NONE;
  end

  assign act = (ev != EV_NONE);
endmodule

// File: rtl/iso_pulse_wdog.sv
module iso_pulse_wdog #(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic act,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  // cnt_q is the number of pulse-free edges since the last pulse, saturating at LAST
  assign expire = pwr_ok && !act && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!pwr_ok || act) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/iso_pulse_hold.sv
module iso_pulse_hold
  import iso_pulse_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_ok,
  input  pulse_ev_t ev,
  input  logic      act,
  input  logic      expire,
  output logic      level,
  output logic      alive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      alive <= 1'b0;
    end else if (!pwr_ok) begin
      level <= 1'b0;
      alive <= 1'b0;
    end else begin
      unique case (ev)
        EV_SET:  level <= 1'b1;
        EV_CLR:  level <= 1'b0;
        default: if (expire) level <= 1'b0;
      endcase
      if (act)         alive <= 1'b1;
      else if (expire) alive <= 1'b0;
    end
  end
endmodule

// File: rtl/iso_pulse_rx.sv
module iso_pulse_rx
  import iso_pulse_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic set_pulse,
  input  logic clr_pulse,
  output logic dout,
  output logic link_ok
);
  pulse_ev_t ev;
  logic      act;
  logic      expire;

  iso_pulse_ev u_ev (
    .pwr_ok    (pwr_ok),
    .set_pulse (set_pulse),
    .clr_pulse (clr_pulse),
    .ev        (ev),
    .act       (act)
  );

  iso_pulse_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .act    (act),
    .expire (expire)
  );

  iso_pulse_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .ev     (ev),
    .act    (act),
    .expire (expire),
    .level  (dout),
    .alive  (link_ok)
  );
endmodule

// File: rtl/iso_pulse_rx_chk.sv
module iso_pulse_rx_chk #(
  parameter int TIMEOUT_CYC = 500
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic set_pulse,
  input logic clr_pulse,
  input logic dout,
  input logic link_ok
);
  localparam int IW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [IW-1:0] LIM = IW'(TIMEOUT_CYC);

  logic [IW-1:0] idle_q;
  logic          any_p;
  assign any_p = pwr_ok && (set_pulse || clr_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            idle_q <= '0;
    else if (any_p)        idle_q <= '0;
    else if (idle_q != LIM) idle_q <= idle_q + 1'b1;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && set_pulse && !clr_pulse) |=> dout);                  // R1
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && clr_pulse) |=> !dout);                               // R2
  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout && !set_pulse) |=> !dout);                               // R3
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(pwr_ok && set_pulse && !clr_pulse));      // R3
  AST_BOTH_IS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && set_pulse && clr_pulse) |=> (!dout && link_ok));     // R4
  AST_PULSE_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    any_p |=> link_ok);                                             // R5
  AST_SILENCE_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q == LIM) |-> (!dout && !link_ok));                       // R6
  AST_UNPOWERED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!dout && !link_ok));                               // R7
  AST_LINK_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> $past(any_p));                               // R8
endmodule

bind iso_pulse_rx iso_pulse_rx_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_ok    (pwr_ok),
  .set_pulse (set_pulse),
  .clr_pulse (clr_pulse),
  .dout      (dout),
  .link_ok   (link_ok)
);

// File: tb/sim_iso_pulse_rx.sv
`timescale 1ns/1ps
module sim_iso_pulse_rx;
  localparam int T = 24;
  localparam int NV = 12;
  // fields: {pwr_ok, set, clr, exp_dout, exp_link}
  localparam logic [4:0] VEC [NV] = '{
    5'b10000, // R8 powered, no pulse yet
    5'b11011, // R1
    5'b10011, // R3 hold high
    5'b10101, // R2
    5'b11011, // R1
    5'b11101, // R4 both -> clear, active
    5'b11011, // R1
    5'b01000, // R7 unpowered, set ignored
    5'b01000, // R7
    5'b10000, // R8 power back, waits
    5'b10101, // R8 first pulse clear
    5'b11011  // R8 first set raises
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic set_pulse = 1'b0;
  logic clr_pulse = 1'b0;
  logic dout, link_ok;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iso_pulse_rx #(.TIMEOUT_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .set_pulse(set_pulse), .clr_pulse(clr_pulse),
    .dout(dout), .link_ok(link_ok)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic p, input logic s, input logic c);
    @(negedge clk);
    pwr_ok = p; set_pulse = s; clr_pulse = c;
    @(posedge clk);
    #2;
    set_pulse = 1'b0; clr_pulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset dout", dout, 1'b0);
    chk("R8 reset link", link_ok, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk("R1-table dout", dout, VEC[i][1]);
      chk("R5-table link", link_ok, VEC[i][0]);
    end

    // R6 boundary: T-1 silent edges keep state, the T-th trips
    step(1, 1, 0);
    for (int i = 0; i < T - 1; i++) step(1, 0, 0);
    chk("R6 before limit dout", dout, 1'b1);
    chk("R6 before limit link", link_ok, 1'b1);
    step(1, 0, 0);
    chk("R6 at limit dout", dout, 1'b0);
    chk("R6 at limit link", link_ok, 1'b0);
    step(1, 0, 0);
    chk("R3 stays tripped", dout, 1'b0);
    step(1, 1, 0);
    chk("R5 recovery dout", dout, 1'b1);
    chk("R5 recovery link", link_ok, 1'b1);

    // R5 restart: pulse at T-2 silent edges, then T-1 more still fine
    for (int i = 0; i < T - 2; i++) step(1, 0, 0);
    step(1, 0, 1);
    chk("R5 restart clear", dout, 1'b0);
    for (int i = 0; i < T - 1; i++) step(1, 0, 0);
    chk("R5 restarted link", link_ok, 1'b1);
    step(1, 0, 0);
    chk("R6 trip after clear", link_ok, 1'b0);

    // R9 healthy refresh never trips
    for (int k = 0; k < 8; k++) begin
      step(1, 1, 0);
      chk("R9 refresh dout", dout, 1'b1);
      for (int i = 0; i < T - 1; i++) begin
        step(1, 0, 0);
        chk("R9 refresh hold", dout & link_ok, 1'b1);
      end
    end

    // R7 power drop mid-run, R8 restart after power
    step(0, 0, 0);
    chk("R7 drop dout", dout, 1'b0);
    chk("R7 drop link", link_ok, 1'b0);
    step(1, 0, 0);
    chk("R8 power back waits", dout | link_ok, 1'b0);
    step(1, 1, 0);
    chk("R8 first set", dout, 1'b1);

    // R8 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk("R8 async reset dout", dout, 1'b0);
    chk("R8 async reset link", link_ok, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule